// File: doc/BRIEF.md
# Banked Word Memory with Decoded Bank Selects

This block is a 2048-word by 8-bit read/write memory assembled from eight independent 256-word banks instead of one flat array. The eight low address bits are shared by every bank as the word offset. The three high address bits feed a 3-to-8 decoder, which drives one active-low select per bank. One read/write line (1 = read, 0 = write) and one global enable are wired in common to all banks. A multiplexer, not a shared tristate bus, returns the selected bank's word.

Writes take effect on the rising clock edge and reach only the selected bank. A read registers the word inside the selected bank and records which bank answered. The word appears on the output after that edge. When the enable is low, no bank is selected, nothing is written and the output keeps its last value. The decoded selects are brought out to a port, so a system can see which bank an access reaches.

Top module: `banked_mem`

## Requirements
- R1: The memory holds 2048 independent 8-bit words addressed by an 11-bit address `addr`. A word written to an address reads back unchanged until that address is written again.
- R2: `addr[7:0]` is the word offset within a bank and `addr[10:8]` is the bank number. Bank k therefore covers addresses k*256 to k*256+255.
- R3: While `memEnable` is 1, exactly one bit of `bankSelN` is 0, and that is bit `addr[10:8]`. This output is combinational from the inputs.
- R4: While `memEnable` is 0, every bit of `bankSelN` is 1.
- R5: An access with `memEnable`=1 and `readNotWrite`=0 stores `wrData` at the rising clock edge into the selected bank only. The same offset in every other bank is left unchanged.
- R6: An access with `memEnable`=1 and `readNotWrite`=1 at a rising edge makes `rdData` equal to the word at `addr` from just after that edge.
- R7: While `memEnable` is 0, no word is written, and `rdData` keeps its value whatever `addr`, `readNotWrite` and `wrData` do.
- R8: An enabled write leaves `rdData` unchanged.
- R9: While `rstN` is 0, and after it until the first enabled read, `rdData` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset of the read path |
| memEnable | input | 1 | Global enable, 1 = respond to the address and read/write line |
| readNotWrite | input | 1 | Shared access direction, 1 = read, 0 = write |
| addr | input | 11 | Word address; the high 3 bits pick the bank, the low 8 bits the offset |
| wrData | input | 8 | Word to store on a write |
| rdData | output | 8 | Word returned by the most recent enabled read |
| bankSelN | output | 8 | Decoded active-low bank selects, one bit per bank |

## Verification
The bench builds the block with its default parameters: an 11-bit address split into 3 bank bits and 8 offset bits, giving eight banks of 256 words. At this size the bench can reach every select code and the first and last offset of every bank. It compares all 2048 locations against a behavioural model, so a mistake in the bank or offset split shows up as aliasing between banks. Disabled writes and reads between enabled accesses check that the output holds and that no storage changes.

// File: rtl/banked_mem_pkg.sv
package banked_mem_pkg;

  // Strobes from the control path to the datapath
  typedef struct packed {
    logic wrStrobe;   // enabled write this cycle
    logic rdStrobe;   // enabled read this cycle
  } memStrobes_t;

  localparam int DEF_ADDR_W     = 11;
  localparam int DEF_DATA_W     = 8;
  localparam int DEF_BANK_SEL_W = 3;

endpackage

// File: rtl/bank_decoder.sv
module bank_decoder #(
  parameter int SEL_W = 3,
  localparam int NUM_OUT = 1 << SEL_W
) (
  input  logic             enable,
  input  logic [SEL_W-1:0] bankIdx,
  output logic [NUM_OUT-1:0] selN
);

  // One active-low line per bank; all lines high when disabled
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_line
    always_comb begin
      selN[g] = ~(enable && (bankIdx == SEL_W'(g)));
    end
  end

endmodule

// File: rtl/bank_ctrl.sv
module bank_ctrl
  import banked_mem_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NUM_BANKS = 1 << SEL_W
) (
  input  logic                 memEnable,
  input  logic                 readNotWrite,
  input  logic [SEL_W-1:0]     bankIdx,
  output memStrobes_t          strobes,
  output logic [NUM_BANKS-1:0] bankSelN
);

  always_comb begin
    strobes          = '0;
    strobes.wrStrobe = memEnable && !readNotWrite;
    strobes.rdStrobe = memEnable &&  readNotWrite;
  end

  bank_decoder #(.SEL_W(SEL_W)) i_decoder (
    .enable  (memEnable),
    .bankIdx (bankIdx),
    .selN    (bankSelN)
  );

endmodule

// File: rtl/bank_store.sv
module bank_store #(
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  localparam int DEPTH = 1 << OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              wrStrobe,
  input  logic              rdStrobe,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdWord
);

  logic [DATA_W-1:0] cells [DEPTH];
  logic              doWrite;
  logic              doRead;

  always_comb begin
    doWrite = !csN && wrStrobe;
    doRead  = !csN && rdStrobe;
  end

  always_ff @(posedge clk) begin
    if (doWrite) begin
      cells[offset] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdWord <= '0;
    end else if (doRead) begin
      rdWord <= cells[offset];
    end
  end

endmodule

// File: rtl/bank_datapath.sv
module bank_datapath
  import banked_mem_pkg::*;
#(
  parameter int SEL_W  = 3,
  parameter int OFF_W  = 8,
  parameter int DATA_W = 8,
  localparam int NUM_BANKS = 1 << SEL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  memStrobes_t          strobes,
  input  logic [NUM_BANKS-1:0] bankSelN,
  input  logic [SEL_W-1:0]     bankIdx,
  input  logic [OFF_W-1:0]     offset,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData
);

  logic [DATA_W-1:0] bankWord [NUM_BANKS];
  logic [SEL_W-1:0]  lastBankQ;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    bank_store #(.OFF_W(OFF_W), .DATA_W(DATA_W)) i_bank (
      .clk      (clk),
      .rstN     (rstN),
      .csN      (bankSelN[g]),
      .wrStrobe (strobes.wrStrobe),
      .rdStrobe (strobes.rdStrobe),
      .offset   (offset),
      .wrData   (wrData),
      .rdWord   (bankWord[g])
    );
  end

  // Remember which bank answered the last read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastBankQ <= '0;
    end else if (strobes.rdStrobe) begin
      lastBankQ <= bankIdx;
    end
  end

  always_comb begin
    rdData = bankWord[lastBankQ];
  end

endmodule

// File: rtl/banked_mem.sv
module banked_mem
  import banked_mem_pkg::*;
#(
  parameter int ADDR_W     = DEF_ADDR_W,
  parameter int DATA_W     = DEF_DATA_W,
  parameter int BANK_SEL_W = DEF_BANK_SEL_W,
  localparam int OFF_W     = ADDR_W - BANK_SEL_W,
  localparam int NUM_BANKS = 1 << BANK_SEL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 memEnable,
  input  logic                 readNotWrite,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic [NUM_BANKS-1:0] bankSelN
);

  memStrobes_t           strobes;
  logic [BANK_SEL_W-1:0] bankIdx;
  logic [OFF_W-1:0]      offset;

  always_comb begin
    bankIdx = addr[ADDR_W-1:OFF_W];
    offset  = addr[OFF_W-1:0];
  end

  bank_ctrl #(.SEL_W(BANK_SEL_W)) i_ctrl (
    .memEnable    (memEnable),
    .readNotWrite (readNotWrite),
    .bankIdx      (bankIdx),
    .strobes      (strobes),
    .bankSelN     (bankSelN)
  );

  bank_datapath #(.SEL_W(BANK_SEL_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .bankSelN (bankSelN),
    .bankIdx  (bankIdx),
    .offset   (offset),
    .wrData   (wrData),
    .rdData   (rdData)
  );

endmodule

// File: rtl/banked_mem_checker.sv
module banked_mem_checker #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int BANK_SEL_W = 3,
  localparam int NUM_BANKS = 1 << BANK_SEL_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 memEnable,
  input logic                 readNotWrite,
  input logic [ADDR_W-1:0]    addr,
  input logic [DATA_W-1:0]    rdData,
  input logic [NUM_BANKS-1:0] bankSelN
);

  p_one_select_r3: assert property (@(posedge clk) disable iff (!rstN)
    memEnable |-> ($countones(~bankSelN) == 1 && !bankSelN[addr[ADDR_W-1:ADDR_W-BANK_SEL_W]]));

  p_idle_deselect_r4: assert property (@(posedge clk) disable iff (!rstN)
    !memEnable |-> (&bankSelN));

  p_hold_disabled_r7: assert property (@(posedge clk) disable iff (!rstN)
    !memEnable |=> $stable(rdData));

  p_hold_on_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (memEnable && !readNotWrite) |=> $stable(rdData));

  p_select_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~bankSelN));

  always_comb begin
    if (!rstN) begin
      a_reset_out_r9: assert (rdData == '0);
    end
  end

endmodule

bind banked_mem banked_mem_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_SEL_W(BANK_SEL_W)
) i_checker (
  .clk          (clk),
  .rstN         (rstN),
  .memEnable    (memEnable),
  .readNotWrite (readNotWrite),
  .addr         (addr),
  .rdData       (rdData),
  .bankSelN     (bankSelN)
);

// File: tb/test_banked_mem.sv
`timescale 1ns/1ps
module test_banked_mem;

  localparam int AW = 11;
  localparam int DW = 8;
  localparam int NB = 8;
  localparam int WORDS = 2048;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          memEnable = 1'b0;
  logic          readNotWrite = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [NB-1:0] bankSelN;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [DW-1:0] refMem [WORDS];
  logic [DW-1:0] expRd = '0;

  always #2.5 clk = ~clk;

  banked_mem i_banked_mem (
    .clk          (clk),
    .rstN         (rstN),
    .memEnable    (memEnable),
    .readNotWrite (readNotWrite),
    .addr         (addr),
    .wrData       (wrData),
    .rdData       (rdData),
    .bankSelN     (bankSelN)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 13) + ((a >> 8) * 29) + 3 + salt);
  endfunction

  // One access: drive after a falling edge, compare on the next falling edge
  task automatic access(input bit en, input bit rd, input int a, input logic [DW-1:0] d);
    logic [NB-1:0] expSel;
    memEnable    = en;
    readNotWrite = rd;
    addr         = AW'(a);
    wrData       = d;
    #1;
    expSel = en ? ~(NB'(1) << (a >> 8)) : '1;
    if (en) check("R3 bank select", 32'(bankSelN), 32'(expSel));
    else    check("R4 idle selects", 32'(bankSelN), 32'(expSel));
    @(posedge clk);
    if (en && !rd) refMem[a] = d;
    if (en && rd)  expRd = refMem[a];
    @(negedge clk);
    if (!en)     check("R7 hold while disabled", 32'(rdData), 32'(expRd));
    else if (rd) check("R6 R1 R2 read data", 32'(rdData), 32'(expRd));
    else         check("R8 hold on write", 32'(rdData), 32'(expRd));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset output", 32'(rdData), 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 output after reset", 32'(rdData), 32'h0);

    // R1: fill every location with a known pattern
    for (int a = 0; a < WORDS; a++) access(1'b1, 1'b0, a, pat(a, 0));
    check("R9 no read yet", 32'(rdData), 32'h0);

    // R2: first and last offset of each bank
    for (int b = 0; b < NB; b++) begin
      access(1'b1, 1'b1, b * 256, '0);
      access(1'b1, 1'b1, b * 256 + 255, '0);
    end

    // R5: write one bank, same offset in the others must stay
    access(1'b1, 1'b0, 3 * 256, 8'hA5);
    access(1'b1, 1'b0, 6 * 256 + 255, 8'h5A);
    for (int b = 0; b < NB; b++) begin
      access(1'b1, 1'b1, b * 256, '0);
      access(1'b1, 1'b1, b * 256 + 255, '0);
    end

    // R7: disabled writes must not land, output holds
    access(1'b1, 1'b1, 100, '0);
    for (int b = 0; b < NB; b++) access(1'b0, 1'b0, b * 256 + 100, 8'hFF);
    access(1'b0, 1'b1, 700, '0);
    for (int b = 0; b < NB; b++) access(1'b1, 1'b1, b * 256 + 100, '0);

    // R8: write between reads must not disturb output
    access(1'b1, 1'b1, 1234, '0);
    access(1'b1, 1'b0, 1234, 8'h3C);
    access(1'b1, 1'b1, 1234, '0);

    // R1: full sweep in a scattered order
    for (int i = 0; i < WORDS; i++) access(1'b1, 1'b1, (i * 37 + 11) % WORDS, '0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule